// File: doc/BRIEF.md
# Stop-Mode Power Sequencer

This block decides when a microcontroller-class system may drop into its deep Stop state and brings it back out again. It watches three kinds of sleep request from the processor core: a wait-for-interrupt, a wait-for-event, and a return from an interrupt handler while sleep-on-exit is armed. A request that qualifies is screened in one check cycle against the core's pending interrupt or event and against every external-line, peripheral and real-time-clock flag. If nothing stands in the way, the sequencer stops the system clock and latches the regulator mode for the stay. If anything is pending, the request is dropped, execution carries on, and a sticky status bit records the refusal.

A wake interrupt or wake event ends the Stop state. The clock source select is forced to the internal RC oscillator at once. The clock stays gated for a startup delay that is counted on a free-running low-speed tick. That delay is longer when the regulator spent the stay in low-power mode. The clock then reopens, and one cycle later a wake-done strobe goes to the core. A clock-failure input returns the source select to the RC oscillator at any time.

Top module: `stop_seq`

## Requirements
- R1: A Stop request is a one-cycle pulse on `wfi_req` or `wfe_req`, or on `isr_ret` while `sleep_on_exit`=1. It is honoured only with `deep_sleep`=1 and `pdown_sel`=0. Any other request is ignored: the clock stays open and `entry_refused` keeps its value.
- R2: A request through `wfi_req` or `isr_ret` is refused while `irq_pending`=1. A request through `wfe_req` is refused while `evt_pending`=1. Each path ignores the other path's pending input.
- R3: A request is refused when any bit of `line_pend` or `periph_pend` is set, or any of the five `rtc_flags` bits is set. The `rtc_flags` bits are 0 alarm A, 1 alarm B, 2 wakeup, 3 tamper and 4 time stamp. On refusal `entry_refused` becomes 1 and `clk_gate_en` stays 1. The flags are sampled in the cycle after the request.
- R4: On a successful entry, `clk_gate_en` falls two cycles after the request pulse and `entry_refused` clears. `reg_lp` takes the value of `lp_sel` sampled in the check cycle. Later changes of `lp_sel` do not affect `reg_lp` during the stay.
- R5: A `wake_irq` or `wake_evt` pulse in Stop sets `clk_src` to 2'b00 (internal RC) on the next cycle. The source encodings are 2'b01 external oscillator and 2'b10 PLL.
- R6: After the wake cycle the clock stays gated for exactly STARTUP_LP `lp_tick` pulses when `reg_lp`=1, and for STARTUP_MAIN pulses otherwise. The defaults are 16 and 4. Cycles without `lp_tick` make no progress.
- R7: `reg_lp` returns to 0 in the same cycle that `clk_gate_en` returns to 1.
- R8: `wake_done` is high for exactly one cycle, the cycle after `clk_gate_en` reopens.
- R9: A wake pulse that arrives in the check cycle aborts entry. The clock stays open, and `clk_src` and `entry_refused` keep their values.
- R10: While `clk_fail`=1 and `clk_src` is not 2'b00, `clk_src` becomes 2'b00 on the next cycle. This takes priority over a software write.
- R11: When the clock is running and no request is being processed, `src_wr` loads `src_wdata` into `clk_src` on the next cycle.
- R12: After reset, `clk_gate_en`=1, `reg_lp`=0, `clk_src`=2'b00, `entry_refused`=0 and `wake_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_tick | input | 1 | Low-speed clock enable used to count the startup delay |
| wfi_req | input | 1 | Wait-for-interrupt sleep request pulse |
| wfe_req | input | 1 | Wait-for-event sleep request pulse |
| isr_ret | input | 1 | Return-from-handler pulse |
| sleep_on_exit | input | 1 | Sleep on return from handler is armed |
| deep_sleep | input | 1 | Deep sleep selected by the core |
| pdown_sel | input | 1 | Power-down selected; the request is then not a Stop request |
| lp_sel | input | 1 | Regulator low-power mode wanted during Stop |
| irq_pending | input | 1 | Core has an interrupt pending |
| evt_pending | input | 1 | Core has an event pending |
| line_pend | input | LINE_W | External-line pending flags |
| periph_pend | input | PERIPH_W | Peripheral interrupt pending flags |
| rtc_flags | input | 5 | Real-time-clock flags (alarm A, alarm B, wakeup, tamper, time stamp) |
| wake_irq | input | 1 | Wakeup interrupt |
| wake_evt | input | 1 | Wakeup event |
| clk_fail | input | 1 | Clock failure detected on the current source |
| src_wr | input | 1 | Software write of the clock source select |
| src_wdata | input | 2 | Value for the clock source select |
| clk_gate_en | output | 1 | System clock gate enable, 1 = clock running |
| reg_lp | output | 1 | Regulator low-power select |
| clk_src | output | 2 | Clock source select |
| entry_refused | output | 1 | The last screened Stop request was refused |
| wake_done | output | 1 | One-cycle strobe when the wake sequence completes |

## Verification
The bench goes after the cross-path pending rules. A design that checks both pending inputs for every request would refuse a wait-for-event while only an interrupt is pending. The bench also covers the sticky refusal bit across requests that never reach the check: a design that clears or sets it on an unqualified request shows the wrong status. The startup count is measured in ticks for both regulator modes and with the tick held low. An off-by-one counter, or one that counts system cycles, reopens the clock at the wrong time. Further cases are a wake that lands in the check cycle, a regulator mode that changes during the stay, and a clock failure that coincides with a software source write. Each of these exposes an abort that still gates the clock, a regulator mode that follows its live input, or a write that beats the failure override.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_CHECK      = 3'd1,
        ST_STOP       = 3'd2,
        ST_WAKE_WAIT  = 3'd3,
        ST_RESTORE    = 3'd4
    } seq_state_e;

    localparam logic [1:0] SRC_RC   = 2'b00;
    localparam logic [1:0] SRC_XOSC = 2'b01;
    localparam logic [1:0] SRC_PLL  = 2'b10;

    localparam int RTC_FLAG_W = 5;

    typedef struct packed {
        seq_state_e state;
        logic       kind_evt;
        logic       reg_lp;
        logic [1:0] src;
        logic       refused;
        logic       done;
    } seq_reg_t;

endpackage

// File: rtl/stop_entry_guard.sv
module stop_entry_guard
    import stop_seq_pkg::*;
#(
    parameter int LINE_W   = 23,
    parameter int PERIPH_W = 8
) (
    input  logic                  wfi_req,
    input  logic                  wfe_req,
    input  logic                  isr_ret,
    input  logic                  sleep_on_exit,
    input  logic                  deep_sleep,
    input  logic                  pdown_sel,
    input  logic                  kind_evt,
    input  logic                  irq_pending,
    input  logic                  evt_pending,
    input  logic [LINE_W-1:0]     line_pend,
    input  logic [PERIPH_W-1:0]   periph_pend,
    input  logic [RTC_FLAG_W-1:0] rtc_flags,
    output logic                  req_valid,
    output logic                  req_evt,
    output logic                  blocked
);

    logic irq_path;
    logic flag_any;

    // Interrupt-style paths win when both kinds arrive together.
    assign irq_path  = wfi_req || (isr_ret && sleep_on_exit);
    assign req_valid = (irq_path || wfe_req) && deep_sleep && !pdown_sel;
    assign req_evt   = wfe_req && !irq_path;

    assign flag_any  = (|line_pend) || (|periph_pend) || (|rtc_flags);
    assign blocked   = flag_any || (kind_evt ? evt_pending : irq_pending);

endmodule

// File: rtl/stop_wake_timer.sv
module stop_wake_timer #(
    parameter int STARTUP_MAIN = 4,
    parameter int STARTUP_LP   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    input  logic tick,
    input  logic lp_mode,
    output logic done
);

    localparam int MAX_CNT = (STARTUP_LP > STARTUP_MAIN) ? STARTUP_LP : STARTUP_MAIN;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] LAST_MAIN = CNT_W'(STARTUP_MAIN - 1);
    localparam logic [CNT_W-1:0] LAST_LP   = CNT_W'(STARTUP_LP - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last  = lp_mode ? LAST_LP : LAST_MAIN;
        done  = run && tick && (cnt_q == last);
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = '0;
        end else if (run && tick && !done) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/stop_seq.sv
module stop_seq
    import stop_seq_pkg::*;
#(
    parameter int LINE_W       = 23,
    parameter int PERIPH_W     = 8,
    parameter int STARTUP_MAIN = 4,
    parameter int STARTUP_LP   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lp_tick,
    input  logic                  wfi_req,
    input  logic                  wfe_req,
    input  logic                  isr_ret,
    input  logic                  sleep_on_exit,
    input  logic                  deep_sleep,
    input  logic                  pdown_sel,
    input  logic                  lp_sel,
    input  logic                  irq_pending,
    input  logic                  evt_pending,
    input  logic [LINE_W-1:0]     line_pend,
    input  logic [PERIPH_W-1:0]   periph_pend,
    input  logic [RTC_FLAG_W-1:0] rtc_flags,
    input  logic                  wake_irq,
    input  logic                  wake_evt,
    input  logic                  clk_fail,
    input  logic                  src_wr,
    input  logic [1:0]            src_wdata,
    output logic                  clk_gate_en,
    output logic                  reg_lp,
    output logic [1:0]            clk_src,
    output logic                  entry_refused,
    output logic                  wake_done
);

    seq_reg_t   r_d, r_q;
    seq_state_e st_q;
    logic       req_valid, req_evt, blocked;
    logic       wake_any;
    logic       tmr_start, tmr_run, tmr_done;

    assign wake_any = wake_irq || wake_evt;
    assign st_q     = r_q.state;

    stop_entry_guard #(
        .LINE_W   (LINE_W),
        .PERIPH_W (PERIPH_W)
    ) i_guard (
        .wfi_req       (wfi_req),
        .wfe_req       (wfe_req),
        .isr_ret       (isr_ret),
        .sleep_on_exit (sleep_on_exit),
        .deep_sleep    (deep_sleep),
        .pdown_sel     (pdown_sel),
        .kind_evt      (r_q.kind_evt),
        .irq_pending   (irq_pending),
        .evt_pending   (evt_pending),
        .line_pend     (line_pend),
        .periph_pend   (periph_pend),
        .rtc_flags     (rtc_flags),
        .req_valid     (req_valid),
        .req_evt       (req_evt),
        .blocked       (blocked)
    );

    stop_wake_timer #(
        .STARTUP_MAIN (STARTUP_MAIN),
        .STARTUP_LP   (STARTUP_LP)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .run     (tmr_run),
        .tick    (lp_tick),
        .lp_mode (r_q.reg_lp),
        .done    (tmr_done)
    );

    assign tmr_run = (r_q.state == ST_WAKE_WAIT);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        tmr_start = 1'b0;
        case (r_q.state)
            ST_RUN: begin
                if (src_wr) begin
                    r_d.src = src_wdata;
                end
                if (req_valid) begin
                    r_d.state    = ST_CHECK;
                    r_d.kind_evt = req_evt;
                end
            end
            ST_CHECK: begin
                if (wake_any) begin
                    r_d.state = ST_RUN;
                end else if (blocked) begin
                    r_d.state   = ST_RUN;
                    r_d.refused = 1'b1;
                end else begin
                    r_d.state   = ST_STOP;
                    r_d.refused = 1'b0;
                    r_d.reg_lp  = lp_sel;
                end
            end
            ST_STOP: begin
                if (wake_any) begin
                    r_d.state = ST_WAKE_WAIT;
                    r_d.src   = SRC_RC;
                    tmr_start = 1'b1;
                end
            end
            ST_WAKE_WAIT: begin
                if (tmr_done) begin
                    r_d.state  = ST_RESTORE;
                    r_d.reg_lp = 1'b0;
                end
            end
            ST_RESTORE: begin
                r_d.state = ST_RUN;
                r_d.done  = 1'b1;
            end
            default: begin
                r_d.state = ST_RUN;
            end
        endcase
        // A failing source never stays selected.
        if (clk_fail && (r_q.src != SRC_RC)) begin
            r_d.src = SRC_RC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_RUN, kind_evt: 1'b0, reg_lp: 1'b0,
                     src: SRC_RC, refused: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign clk_gate_en   = !((r_q.state == ST_STOP) || (r_q.state == ST_WAKE_WAIT));
    assign reg_lp        = r_q.reg_lp;
    assign clk_src       = r_q.src;
    assign entry_refused = r_q.refused;
    assign wake_done     = r_q.done;

endmodule

// File: rtl/stop_seq_chk.sv
module stop_seq_chk
    import stop_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input seq_state_e state,
    input logic       pdown_sel,
    input logic       wake_irq,
    input logic       wake_evt,
    input logic       clk_fail,
    input logic       clk_gate_en,
    input logic       reg_lp,
    input logic [1:0] clk_src,
    input logic       entry_refused,
    input logic       wake_done
);

    // R1
    pdown_no_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && pdown_sel) |=> state == ST_RUN);

    // R4
    gate_fall_clears_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_gate_en) |-> !entry_refused);

    // R5
    wake_forces_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && (wake_irq || wake_evt)) |=> clk_src == SRC_RC);

    // R7
    reg_lp_only_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_lp |-> !clk_gate_en);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !wake_done);

    // R8
    done_after_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |-> (clk_gate_en && $past(clk_gate_en) && !$past(wake_done)));

    // R10
    fail_to_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_fail && clk_src != SRC_RC) |=> clk_src == SRC_RC);

endmodule

bind stop_seq stop_seq_chk i_stop_seq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (st_q),
    .pdown_sel     (pdown_sel),
    .wake_irq      (wake_irq),
    .wake_evt      (wake_evt),
    .clk_fail      (clk_fail),
    .clk_gate_en   (clk_gate_en),
    .reg_lp        (reg_lp),
    .clk_src       (clk_src),
    .entry_refused (entry_refused),
    .wake_done     (wake_done)
);

// File: tb/test_stop_seq.sv
module test_stop_seq;

    localparam int LINE_W = 23;
    localparam int PERIPH_W = 8;
    localparam int T_MAIN = 4;
    localparam int T_LP = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_tick = 1'b1;
    logic wfi_req = 0, wfe_req = 0, isr_ret = 0;
    logic sleep_on_exit = 0, deep_sleep = 0, pdown_sel = 0, lp_sel = 0;
    logic irq_pending = 0, evt_pending = 0;
    logic [LINE_W-1:0] line_pend = '0;
    logic [PERIPH_W-1:0] periph_pend = '0;
    logic [4:0] rtc_flags = '0;
    logic wake_irq = 0, wake_evt = 0, clk_fail = 0, src_wr = 0;
    logic [1:0] src_wdata = 2'b00;
    logic clk_gate_en, reg_lp, entry_refused, wake_done;
    logic [1:0] clk_src;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    stop_seq #(
        .LINE_W(LINE_W), .PERIPH_W(PERIPH_W),
        .STARTUP_MAIN(T_MAIN), .STARTUP_LP(T_LP)
    ) i_stop_seq (
        .clk(clk), .rst_n(rst_n), .lp_tick(lp_tick),
        .wfi_req(wfi_req), .wfe_req(wfe_req), .isr_ret(isr_ret),
        .sleep_on_exit(sleep_on_exit), .deep_sleep(deep_sleep),
        .pdown_sel(pdown_sel), .lp_sel(lp_sel),
        .irq_pending(irq_pending), .evt_pending(evt_pending),
        .line_pend(line_pend), .periph_pend(periph_pend), .rtc_flags(rtc_flags),
        .wake_irq(wake_irq), .wake_evt(wake_evt), .clk_fail(clk_fail),
        .src_wr(src_wr), .src_wdata(src_wdata),
        .clk_gate_en(clk_gate_en), .reg_lp(reg_lp), .clk_src(clk_src),
        .entry_refused(entry_refused), .wake_done(wake_done)
    );

    // [13:12] kind 0 wfi 1 wfe 2 isr, [11] deep, [10] pdown, [9] soe, [8] irqp,
    // [7] evtp, [6] line, [5] periph, [4] rtc, [3:2] unused, [1] exp_stop, [0] exp_refused
    localparam int NV = 14;
    localparam logic [13:0] TBL [NV] = '{
        14'b00_1000_0000_0010, // clean wfi enters
        14'b00_1001_0000_0001, // wfi with irq pending
        14'b01_1001_0000_0010, // wfe ignores irq pending
        14'b01_1000_1000_0001, // wfe with evt pending
        14'b00_0000_0000_0001, // no deep sleep: unchanged
        14'b00_1100_0000_0001, // power-down selected: unchanged
        14'b00_1000_1000_0010, // wfi ignores evt pending
        14'b10_1000_0000_0000, // isr without sleep-on-exit: unchanged
        14'b10_1010_0000_0010, // isr with sleep-on-exit enters
        14'b10_1011_0000_0001, // isr with irq pending
        14'b00_1000_0100_0001, // line flag
        14'b01_1000_0010_0001, // peripheral flag
        14'b00_1000_0001_0001, // rtc flag
        14'b00_1000_0000_0010  // clean again
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input logic [1:0] kind);
        @(negedge clk);
        wfi_req = (kind == 2'd0);
        wfe_req = (kind == 2'd1);
        isr_ret = (kind == 2'd2);
        @(negedge clk);
        wfi_req = 0; wfe_req = 0; isr_ret = 0;
    endtask

    // Wake from Stop, measure gated cycles, then check the done strobe.
    task automatic wake_measure(input int exp_n, input string tag);
        int n;
        @(negedge clk); wake_evt = 1;
        @(negedge clk); wake_evt = 0;
        check({tag, " R5 source RC after wake"}, 32'(clk_src), 32'(2'b00));
        n = 0;
        while (!clk_gate_en && n < 200) begin
            @(negedge clk);
            n++;
        end
        check({tag, " R6 startup ticks"}, 32'(n), 32'(exp_n));
        check({tag, " R7 reg_lp low on reopen"}, 32'(reg_lp), 0);
        check({tag, " R8 done not yet"}, 32'(wake_done), 0);
        @(negedge clk);
        check({tag, " R8 done strobe"}, 32'(wake_done), 1);
        @(negedge clk);
        check({tag, " R8 done one cycle"}, 32'(wake_done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12
        check("R12 gate", 32'(clk_gate_en), 1);
        check("R12 reg_lp", 32'(reg_lp), 0);
        check("R12 src", 32'(clk_src), 0);
        check("R12 refused", 32'(entry_refused), 0);
        check("R12 done", 32'(wake_done), 0);

        // Table walk: R1, R2, R3, R4
        for (int i = 0; i < NV; i++) begin
            logic [13:0] v;
            v = TBL[i];
            @(negedge clk);
            deep_sleep = v[11]; pdown_sel = v[10]; sleep_on_exit = v[9];
            irq_pending = v[8]; evt_pending = v[7];
            line_pend = {{(LINE_W-1){1'b0}}, v[6]} << (i % LINE_W);
            periph_pend = {{(PERIPH_W-1){1'b0}}, v[5]} << (i % PERIPH_W);
            rtc_flags = {4'b0, v[4]} << (i % 5);
            pulse_req(v[13:12]);
            @(negedge clk);
            check($sformatf("R1 R2 R3 R4 vec %0d gate", i), 32'(clk_gate_en), 32'(!v[1]));
            check($sformatf("R1 R2 R3 R4 vec %0d refused", i), 32'(entry_refused), 32'(v[0]));
            irq_pending = 0; evt_pending = 0;
            line_pend = '0; periph_pend = '0; rtc_flags = '0;
            if (v[1]) wake_measure(T_MAIN, $sformatf("vec %0d", i));
        end

        // R3: each rtc flag alone refuses
        for (int b = 0; b < 5; b++) begin
            @(negedge clk);
            deep_sleep = 1; pdown_sel = 0;
            rtc_flags = 5'(1 << b);
            pulse_req(2'd1);
            @(negedge clk);
            check($sformatf("R3 rtc bit %0d gate", b), 32'(clk_gate_en), 1);
            check($sformatf("R3 rtc bit %0d refused", b), 32'(entry_refused), 1);
            rtc_flags = '0;
        end

        // R11: software write of source
        @(negedge clk); src_wr = 1; src_wdata = 2'b10;
        @(negedge clk); src_wr = 0;
        check("R11 write PLL", 32'(clk_src), 32'(2'b10));

        // R9: wake during the check cycle aborts
        @(negedge clk); wfi_req = 1;
        @(negedge clk); wfi_req = 0; wake_irq = 1;
        @(negedge clk); wake_irq = 0;
        check("R9 abort gate open", 32'(clk_gate_en), 1);
        check("R9 abort src kept", 32'(clk_src), 32'(2'b10));
        check("R9 abort refused kept", 32'(entry_refused), 1);
        @(negedge clk);
        check("R9 abort stays open", 32'(clk_gate_en), 1);

        // R4, R5, R6, R7: low-power entry from PLL
        lp_sel = 1;
        pulse_req(2'd1);
        @(negedge clk);
        check("R4 lp entry gate", 32'(clk_gate_en), 0);
        check("R4 lp entry refused cleared", 32'(entry_refused), 0);
        check("R4 reg_lp latched", 32'(reg_lp), 1);
        lp_sel = 0;
        repeat (3) @(negedge clk);
        check("R4 reg_lp held", 32'(reg_lp), 1);
        check("R5 src kept in stop", 32'(clk_src), 32'(2'b10));
        wake_measure(T_LP, "lp");

        // R6: no ticks, no progress
        pulse_req(2'd0);
        @(negedge clk);
        check("R4 main entry reg_lp", 32'(reg_lp), 0);
        lp_tick = 0;
        @(negedge clk); wake_evt = 1;
        @(negedge clk); wake_evt = 0;
        repeat (30) @(negedge clk);
        check("R6 stalled without tick", 32'(clk_gate_en), 0);
        lp_tick = 1;
        begin
            int n;
            n = 0;
            while (!clk_gate_en && n < 200) begin
                @(negedge clk);
                n++;
            end
            check("R6 ticks after stall", 32'(n), T_MAIN);
        end
        repeat (2) @(negedge clk);

        // R10: clock failure
        @(negedge clk); src_wr = 1; src_wdata = 2'b01;
        @(negedge clk); src_wr = 0;
        check("R11 write external", 32'(clk_src), 32'(2'b01));
        clk_fail = 1;
        @(negedge clk);
        check("R10 fail forces RC", 32'(clk_src), 0);
        clk_fail = 0;
        @(negedge clk); src_wr = 1; src_wdata = 2'b01;
        @(negedge clk); src_wdata = 2'b10; clk_fail = 1;
        @(negedge clk); src_wr = 0; clk_fail = 0;
        check("R10 fail beats write", 32'(clk_src), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule